// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a packet DMA engine. Frames arrive one byte per beat on an AXI4-Stream-style interface. Each accepted frame goes into the buffer that belongs to the next ring slot. Every slot owns a fixed 2048-byte buffer, placed at `buf_base_i + slot * 2048`. Each byte goes out on a byte-wide memory write port. When the last beat of a frame arrives, the block records the stored length in that slot's status word and advances a 16-bit producer index. The slot used is the producer index modulo 256.

Software returns buffers by advancing a 16-bit consumer index, which it presents on `cons_idx_i`. The block derives ring occupancy from the two indices. When all 256 slots are in use, the block consumes each new frame without writing it and counts it as dropped. A hysteresis flag asks the upstream MAC to pause while few slots remain free. An optional mode writes two zero bytes ahead of each frame, so that the network header behind the 14-byte Ethernet header lands on a 4-byte boundary. The block samples this mode at the start of each frame. Software reads the status words and buffer addresses through a combinational read port.

Top module: `rxr_dma_writer`

## Requirements
- R1: After reset, `prod_idx_o`, `drop_cnt_o`, `xoff_o` and `ring_full_o` are 0. Every status word reads 0x0800_8000: length 2048 in bits 27:16 and the owner flag in bit 15.
- R2: With alignment off, byte k of a frame (k counted from 0) is written to address `buf_base_i + slot*2048 + k`. The slot is `prod_idx_o` mod 256, taken when the frame starts.
- R3: With `align_en_i` high at frame start, value 0x00 is written at buffer offsets 0 and 1. Frame byte k then goes to offset k+2, and the recorded length includes the two pad bytes.
- R4: When the last beat of a stored frame is accepted, the slot's status word becomes length<<16 | bit14 | bit13, with bit 15 and bit 0 clear. `prod_idx_o` then rises by exactly 1 on that clock edge.
- R5: Bytes beyond offset 2047 (pad included) are never written. A frame that overflows its buffer is recorded with length 2048 and error bit 0 set. A frame of exactly 2048 bytes has the error bit clear.
- R6: Occupancy is (`prod_idx_o` - `cons_idx_i`) mod 65536. `ring_full_o` is high exactly when occupancy equals 256, and no frame completes into a full ring.
- R7: A frame whose first beat finds the ring full is consumed with no memory write and no change to `prod_idx_o`. `drop_cnt_o` rises by 1 when its last beat is accepted.
- R8: One clock after free slots (256 - occupancy) are 5 or fewer, `xoff_o` is high. `xoff_o` clears one clock after free slots exceed 16, and holds its value in between.
- R9: `desc_addr_o` equals `buf_base_i + desc_sel_i*2048`, and `desc_status_o` is the status word of slot `desc_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_en_i | input | 1 | Insert two pad bytes ahead of each frame |
| buf_base_i | input | 32 | Byte address of slot 0's buffer |
| cons_idx_i | input | 16 | Consumer index written by software |
| s_tdata_i | input | 8 | Stream byte |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tlast_i | input | 1 | Last beat of frame |
| s_tready_o | output | 1 | Stream beat accepted |
| wr_en_o | output | 1 | Memory byte write strobe |
| wr_addr_o | output | 32 | Memory byte address |
| wr_data_o | output | 8 | Memory byte data |
| prod_idx_o | output | 16 | Producer index |
| ring_full_o | output | 1 | All 256 slots occupied |
| xoff_o | output | 1 | Pause request to upstream |
| drop_cnt_o | output | 16 | Frames dropped on a full ring |
| desc_sel_i | input | 8 | Slot selected for readout |
| desc_status_o | output | 32 | Status word of selected slot |
| desc_addr_o | output | 32 | Buffer address of selected slot |

## Verification
The bench goes after the buffer boundary from both sides. It sends a frame of exactly 2048 bytes and an aligned frame of 2046 bytes, where a wrong comparison would flag a false error. It also sends overflowing frames with and without the pad, where a design that got this wrong would write into the next slot's buffer or record a wrapped length. The bench fills the ring to exactly 256 frames, sends frames into the full ring, and then wraps the slot number past 255. An off-by-one in the full test would either overwrite a slot software still holds or drop one frame too early. It moves the consumer index through the band between the two pause thresholds, where a missing hysteresis would toggle `xoff_o` at the wrong point.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAD0,
    ST_PAD1,
    ST_DATA,
    ST_DROP
  } rxr_state_e;

  localparam int LEN_LSB = 16;
  localparam int OWN_BIT = 15;
  localparam int EOP_BIT = 14;
  localparam int SOP_BIT = 13;
  localparam int ERR_BIT = 0;
endpackage

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl #(
  parameter int NUM_DESC  = 256,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 16,
  parameter int XOFF_FREE = 5,
  parameter int XON_FREE  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             drop_i,
  input  logic [IDX_W-1:0] cons_idx_i,
  output logic [IDX_W-1:0] prod_idx_o,
  output logic             full_o,
  output logic             xoff_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  localparam logic [IDX_W:0] RING_N = (IDX_W+1)'(NUM_DESC);
  localparam logic [IDX_W:0] LO_TH  = (IDX_W+1)'(XOFF_FREE);
  localparam logic [IDX_W:0] HI_TH  = (IDX_W+1)'(XON_FREE);

  logic [IDX_W-1:0] prod_q, occ;
  logic [IDX_W:0]   free_w;
  logic [CNT_W-1:0] drop_q;
  logic             xoff_q;

  assign occ    = prod_q - cons_idx_i;
  assign free_w = RING_N - {1'b0, occ};
  assign full_o = ({1'b0, occ} == RING_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      drop_q <= '0;
      xoff_q <= 1'b0;
    end else begin
      if (advance_i) prod_q <= prod_q + 1'b1;
      if (drop_i)    drop_q <= drop_q + 1'b1;
      if (free_w <= LO_TH)     xoff_q <= 1'b1;
      else if (free_w > HI_TH) xoff_q <= 1'b0;
    end
  end

  assign prod_idx_o = prod_q;
  assign xoff_o     = xoff_q;
  assign drop_cnt_o = drop_q;

  assert_prod_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_q != $past(prod_q)) |-> (prod_q == IDX_W'($past(prod_q) + 1'b1)));
  assert_xoff_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_w <= LO_TH) |=> xoff_q);
  assert_xoff_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_w > HI_TH) |=> !xoff_q);
endmodule

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
  parameter int NUM_DESC  = 256,
  parameter int BUF_BYTES = 2048,
  localparam int SLOT_W   = $clog2(NUM_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [31:0]       wr_word_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [31:0]       rd_word_o
);
  import rxr_pkg::*;
  localparam logic [31:0] INIT_WORD =
    (32'(BUF_BYTES) << LEN_LSB) | (32'd1 << OWN_BIT);

  logic [31:0] ent_q [NUM_DESC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DESC; i++) ent_q[i] <= INIT_WORD;
    end else if (wr_i) begin
      ent_q[wr_slot_i] <= wr_word_i;
    end
  end

  assign rd_word_o = ent_q[rd_slot_i];

  assert_done_clears_own_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !ent_q[$past(wr_slot_i)][OWN_BIT]);
endmodule

// File: rtl/rxr_wr_fsm.sv
module rxr_wr_fsm #(
  parameter int BUF_BYTES = 2048,
  localparam int LEN_W    = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             align_i,
  input  logic             full_i,
  input  logic [7:0]       tdata_i,
  input  logic             tvalid_i,
  input  logic             tlast_i,
  output logic             tready_o,
  output logic             wr_en_o,
  output logic [LEN_W-1:0] wr_off_o,
  output logic [7:0]       wr_data_o,
  output logic             done_o,
  output logic [LEN_W-1:0] done_len_o,
  output logic             done_err_o,
  output logic             drop_o
);
  import rxr_pkg::*;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

  rxr_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic             err_q, room;

  assign room = (cnt_q < CAP);

  always_comb begin
    tready_o   = 1'b0;
    wr_en_o    = 1'b0;
    wr_off_o   = cnt_q;
    wr_data_o  = 8'h00;
    done_o     = 1'b0;
    drop_o     = 1'b0;
    done_len_o = cnt_q + LEN_W'(room);
    done_err_o = err_q | ~room;
    case (state_q)
      ST_PAD0, ST_PAD1: wr_en_o = 1'b1;
      ST_DATA: begin
        tready_o  = 1'b1;
        wr_en_o   = tvalid_i & room;
        wr_data_o = tdata_i;
        done_o    = tvalid_i & tlast_i;
      end
      ST_DROP: begin
        tready_o = 1'b1;
        drop_o   = tvalid_i & tlast_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (tvalid_i) begin
          cnt_q <= '0;
          err_q <= 1'b0;
          if (full_i)       state_q <= ST_DROP;
          else if (align_i) state_q <= ST_PAD0;
          else              state_q <= ST_DATA;
        end
        ST_PAD0: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= ST_PAD1;
        end
        ST_PAD1: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= ST_DATA;
        end
        ST_DATA: if (tvalid_i) begin
          if (room) cnt_q <= cnt_q + 1'b1;
          else      err_q <= 1'b1;
          if (tlast_i) state_q <= ST_IDLE;
        end
        ST_DROP: if (tvalid_i && tlast_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_wr_in_buffer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_off_o < CAP));
  assert_full_goes_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tvalid_i && full_i) |=> (state_q == ST_DROP));
  assert_len_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_len_o <= CAP));
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer #(
  parameter int NUM_DESC  = 256,
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 16,
  parameter int XOFF_FREE = 5,
  parameter int XON_FREE  = 16,
  localparam int SLOT_W   = $clog2(NUM_DESC),
  localparam int BUF_LG   = $clog2(BUF_BYTES),
  localparam int LEN_W    = BUF_LG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              align_en_i,
  input  logic [ADDR_W-1:0] buf_base_i,
  input  logic [IDX_W-1:0]  cons_idx_i,
  input  logic [7:0]        s_tdata_i,
  input  logic              s_tvalid_i,
  input  logic              s_tlast_i,
  output logic              s_tready_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [IDX_W-1:0]  prod_idx_o,
  output logic              ring_full_o,
  output logic              xoff_o,
  output logic [CNT_W-1:0]  drop_cnt_o,
  input  logic [SLOT_W-1:0] desc_sel_i,
  output logic [31:0]       desc_status_o,
  output logic [ADDR_W-1:0] desc_addr_o
);
  import rxr_pkg::*;

  logic             done, done_err, drop;
  logic [LEN_W-1:0] done_len, wr_off;
  logic [SLOT_W-1:0] slot;
  logic [31:0]      done_word;

  rxr_ring_ctrl #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .XOFF_FREE(XOFF_FREE), .XON_FREE(XON_FREE)
  ) u_ring (
    .clk_i, .rst_ni,
    .advance_i (done),
    .drop_i    (drop),
    .cons_idx_i,
    .prod_idx_o,
    .full_o    (ring_full_o),
    .xoff_o,
    .drop_cnt_o
  );

  rxr_wr_fsm #(.BUF_BYTES(BUF_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .align_i    (align_en_i),
    .full_i     (ring_full_o),
    .tdata_i    (s_tdata_i),
    .tvalid_i   (s_tvalid_i),
    .tlast_i    (s_tlast_i),
    .tready_o   (s_tready_o),
    .wr_en_o,
    .wr_off_o   (wr_off),
    .wr_data_o,
    .done_o     (done),
    .done_len_o (done_len),
    .done_err_o (done_err),
    .drop_o     (drop)
  );

  assign slot      = prod_idx_o[SLOT_W-1:0];
  assign wr_addr_o = buf_base_i + (ADDR_W'(slot) << BUF_LG) + ADDR_W'(wr_off);
  assign done_word = (32'(done_len) << LEN_LSB) | (32'd1 << EOP_BIT) |
                     (32'd1 << SOP_BIT) | (32'(done_err) << ERR_BIT);

  rxr_desc_store #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_desc (
    .clk_i, .rst_ni,
    .wr_i      (done),
    .wr_slot_i (slot),
    .wr_word_i (done_word),
    .rd_slot_i (desc_sel_i),
    .rd_word_o (desc_status_o)
  );

  assign desc_addr_o = buf_base_i + (ADDR_W'(desc_sel_i) << BUF_LG);

  assert_no_done_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !ring_full_o);
  assert_drop_no_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> $stable(prod_idx_o));
endmodule

// File: tb/tb_rxr_dma_writer.sv
`timescale 1ns/1ps
module tb_rxr_dma_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        align_en = 1'b0;
  logic [31:0] base = 32'h8000_0000;
  logic [15:0] cons = '0;
  logic [7:0]  tdata = '0;
  logic        tvalid = 1'b0, tlast = 1'b0;
  logic        tready, wr_en, full, xoff;
  logic [31:0] wr_addr, dstat, daddr;
  logic [7:0]  wr_data, dsel = '0;
  logic [15:0] prod, dropc;

  always #2.5 clk = ~clk;

  rxr_dma_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .align_en_i(align_en), .buf_base_i(base),
    .cons_idx_i(cons), .s_tdata_i(tdata), .s_tvalid_i(tvalid), .s_tlast_i(tlast),
    .s_tready_o(tready), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .prod_idx_o(prod), .ring_full_o(full), .xoff_o(xoff), .drop_cnt_o(dropc),
    .desc_sel_i(dsel), .desc_status_o(dstat), .desc_addr_o(daddr)
  );

  int checks = 0, fails = 0;
  logic [15:0] m_prod = '0, m_drop = '0;
  logic        m_xoff = 1'b0, m_dropping = 1'b0, acc = 1'b0, mon_on = 1'b0;
  logic [31:0] m_status [256];
  logic [31:0] pend_status;
  logic [39:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, evaluated away from the active edge
  always @(negedge clk) if (mon_on) begin
    logic [15:0] occ;
    int fr;
    logic nx;
    chk(prod == m_prod, "R4 prod_idx", 40'(prod), 40'(m_prod));
    chk(dropc == m_drop, "R7 drop_cnt", 40'(dropc), 40'(m_drop));
    chk(xoff == m_xoff, "R8 xoff", 40'(xoff), 40'(m_xoff));
    occ = m_prod - cons;
    chk(full == (occ == 16'd256), "R6 ring_full", 40'(full), 40'(occ == 16'd256));
    if (wr_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected write", {wr_addr, wr_data}, 40'h0);
      else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R2/R3 write addr,data", {wr_addr, wr_data}, e);
      end
    end
    acc = tvalid && tready;
    fr = 256 - int'(occ);
    nx = (fr <= 5) ? 1'b1 : (fr > 16) ? 1'b0 : m_xoff;
    if (acc && tlast) begin
      if (m_dropping) m_drop++;
      else begin
        m_status[m_prod[7:0]] = pend_status;
        m_prod++;
      end
    end
    m_xoff = nx;
  end

  task automatic send_frame(input int len, input logic [7:0] seed);
    int off;
    logic [15:0] occ;
    occ = m_prod - cons;
    m_dropping = (occ == 16'd256);
    if (!m_dropping) begin
      logic err;
      off = 0;
      err = 1'b0;
      if (align_en) begin
        exp_q.push_back({base + {m_prod[7:0], 11'd0}, 8'h00});
        exp_q.push_back({base + {m_prod[7:0], 11'd0} + 32'd1, 8'h00});
        off = 2;
      end
      for (int k = 0; k < len; k++) begin
        if (off < 2048) begin
          exp_q.push_back({base + {m_prod[7:0], 11'd0} + 32'(off), 8'(seed + k)});
          off++;
        end else err = 1'b1;
      end
      pend_status = (32'(off) << 16) | 32'h6000 | 32'(err);
    end
    for (int k = 0; k < len; k++) begin
      tdata  = 8'(seed + k);
      tvalid = 1'b1;
      tlast  = (k == len - 1);
      do @(posedge clk); while (!acc);
      #1;
    end
    tvalid = 1'b0;
    tlast  = 1'b0;
  endtask

  task automatic check_desc(input int s, input string req);
    dsel = 8'(s);
    @(negedge clk);
    chk(dstat == m_status[s], req, 40'(dstat), 40'(m_status[s]));
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_status[i] = 32'h0800_8000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(prod == 0 && dropc == 0 && !xoff && !full, "R1 reset outputs",
        {prod, dropc, 6'b0, xoff, full}, 40'h0);
    @(posedge clk); #1;
    mon_on = 1'b1;
    for (int i = 0; i < 256; i++) check_desc(i, "R1 init status");
    dsel = 8'd37;
    @(negedge clk);
    chk(daddr == base + 32'd37 * 32'd2048, "R9 desc_addr", 40'(daddr), 40'(base + 32'd37 * 32'd2048));
    @(posedge clk); #1;
    dsel = 8'd255;
    @(negedge clk);
    chk(daddr == base + 32'd255 * 32'd2048, "R9 desc_addr top", 40'(daddr), 40'(base + 32'd255 * 32'd2048));
    @(posedge clk); #1;

    // R2/R4: plain frames
    send_frame(1, 8'h10);
    send_frame(60, 8'h20);
    send_frame(64, 8'hA0);
    // R3: aligned frames
    align_en = 1'b1;
    send_frame(1, 8'h33);
    send_frame(100, 8'h44);
    // R5: buffer boundary
    send_frame(2046, 8'h01);
    send_frame(2047, 8'h02);
    align_en = 1'b0;
    send_frame(2048, 8'h03);
    send_frame(2050, 8'h04);
    for (int i = 0; i < 9; i++) check_desc(i, "R4/R5 status word");

    // R6/R7/R8: fill the ring
    while (16'(m_prod - cons) != 16'd256) send_frame(1, 8'(m_prod));
    repeat (2) @(posedge clk); #1;
    send_frame(1, 8'h77);
    send_frame(3, 8'h78);
    repeat (2) @(posedge clk); #1;
    chk(dropc == 16'd2, "R7 two drops", 40'(dropc), 40'd2);
    cons = cons + 16'd12;
    repeat (3) @(posedge clk); #1;
    cons = cons + 16'd5;
    repeat (3) @(posedge clk); #1;
    // slot reuse past 255
    send_frame(5, 8'h90);
    send_frame(7, 8'h91);
    align_en = 1'b1;
    send_frame(9, 8'h92);
    align_en = 1'b0;
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < 256; i++) check_desc(i, "R4 status after wrap");
    cons = m_prod;
    repeat (3) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 pending writes", 40'(exp_q.size()), 40'd0);
    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule